// File: doc/BRIEF.md
# Reset-Selected Shared Output Multiplexer

This block lets four on-chip sub-blocks share one 16-bit group of chip output pins. The four sources have data words of different widths: 7, 8, 12 and 16 bits. There is no encoded select bus. The source shown on the pins is chosen by the sub-blocks' own active-low reset lines. When exactly one of those lines is held low, that source's word is placed on the low bits of the output. Every output bit above the source's width is driven to logic one.

Any other reset pattern makes the output all ones and clears a valid flag. That covers the case where no line is low and the case where two or more lines are low. The reset lines are level-sensitive select inputs and have no edge detection.

A parameter picks the output stage. One option is purely combinational. The other, which is the default, registers the output on the rising clock edge with one cycle of latency. In the registered option a synchronous active-low global reset forces the output to all ones and the flag to zero.

Top module: `dbg_out_mux`

## Requirements
- R1: With only `src_a_rst_n` low, `mux_data[6:0]` equals `src_a_data` and `mux_data[15:7]` are all ones.
- R2: With only `src_b_rst_n` low, `mux_data[7:0]` equals `src_b_data` and `mux_data[15:8]` are all ones.
- R3: With only `src_c_rst_n` low, `mux_data[11:0]` equals `src_c_data` and `mux_data[15:12]` are all ones.
- R4: With only `src_d_rst_n` low, all 16 bits of `mux_data` equal `src_d_data`.
- R5: When no reset line is low, or when two or more are low, `mux_data` is 16'hFFFF.
- R6: `mux_valid` is 1 exactly when exactly one of the four reset lines is low, and 0 otherwise.
- R7: In registered mode (`REGISTERED`=1), each output reflects the inputs present at the preceding rising clock edge. The output holds its value between edges.
- R8: In registered mode, `rst_n` low at a rising edge makes `mux_data` 16'hFFFF and `mux_valid` 0 after that edge, whatever the other inputs are.
- R9: The data inputs of the sources that are not selected have no effect on `mux_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered output stage |
| rst_n | input | 1 | Synchronous active-low reset of the output stage |
| src_a_data | input | 7 | Data word of source A |
| src_b_data | input | 8 | Data word of source B |
| src_c_data | input | 12 | Data word of source C |
| src_d_data | input | 16 | Data word of source D |
| src_a_rst_n | input | 1 | Reset line of source A, used as its select (active low) |
| src_b_rst_n | input | 1 | Reset line of source B, used as its select (active low) |
| src_c_rst_n | input | 1 | Reset line of source C, used as its select (active low) |
| src_d_rst_n | input | 1 | Reset line of source D, used as its select (active low) |
| mux_data | output | 16 | Shared output word, padded with ones above the source width |
| mux_valid | output | 1 | High when exactly one reset line is low |

## Verification
The only state in the block is the output register, so any fault shows at the pins no later than one clock edge after the inputs that caused it. A wrong select decode drives the wrong source, zero padding in place of ones, or a valid flag that disagrees with the count of low reset lines. All 16 reset patterns, each with fresh random data on every source, are checked in the cycle after they are applied. The bench also samples mid-cycle, before the next edge, so it catches an output that changes too early or a latency slip. Changing only the unselected sources' data exposes any leakage between sources.

// File: rtl/dbg_out_mux_pkg.sv
// Package: dbg_out_mux_pkg
// Shared widths and types for the reset-selected output multiplexer.
// Assumes the source order A, B, C, D maps to select vector bits 0..3.
package dbg_out_mux_pkg;
    localparam int unsigned OUT_W = 16;
    localparam int unsigned N_SRC = 4;

    typedef logic [OUT_W-1:0] word_t;
    typedef logic [N_SRC-1:0] sel_t;

    // Bit position of each source in the select vectors
    typedef enum int unsigned {
        SRC_IDX_A = 0,
        SRC_IDX_B = 1,
        SRC_IDX_C = 2,
        SRC_IDX_D = 3
    } src_idx_e;
endpackage

// File: rtl/dbg_out_mux_pad.sv
// Module: dbg_out_mux_pad
// Widens one source word to the output width and fills the unused upper
// bits with ones. Assumes IN_W >= 1. A source as wide as the output, or
// wider, is passed through truncated to OUT_W bits.
module dbg_out_mux_pad #(
    parameter int unsigned IN_W  = 7,
    parameter int unsigned OUT_W = 16
) (
    input  logic [IN_W-1:0]  din,
    output logic [OUT_W-1:0] dout
);
    localparam int unsigned FILL_W = (IN_W < OUT_W) ? (OUT_W - IN_W) : 0;

    generate
        if (FILL_W > 0) begin : g_fill
            // Narrow source: ones above, data below
            assign dout = {{FILL_W{1'b1}}, din};
        end else begin : g_full
            // Full-width source: straight pass
            assign dout = din[OUT_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/dbg_out_mux_sel.sv
// Module: dbg_out_mux_sel
// Turns the sources' active-low reset lines into a one-hot select and a
// valid flag. The select is one-hot only when exactly one line is low;
// otherwise it is all zeros. The lines are treated as plain levels.
module dbg_out_mux_sel #(
    parameter int unsigned N_SRC = 4
) (
    input  logic [N_SRC-1:0] rst_lines_n,
    output logic [N_SRC-1:0] sel_oh,
    output logic             sel_valid
);
    localparam int unsigned CNT_W = $clog2(N_SRC + 1);

    logic [CNT_W-1:0] low_cnt;

    // Count how many reset lines are currently held low
    always_comb begin
        low_cnt = '0;
        for (int i = 0; i < N_SRC; i++) begin
            low_cnt = low_cnt + CNT_W'(!rst_lines_n[i]);
        end
    end

    // Accept only a single low line; anything else selects nothing
    always_comb begin
        sel_valid = (low_cnt == CNT_W'(1));
        sel_oh    = sel_valid ? ~rst_lines_n : '0;
    end

    // Guard: the select never names two sources at once
    always_comb begin
        AST_SEL_ONEHOT: assert ($onehot0(sel_oh)); // R5
    end
endmodule

// File: rtl/dbg_out_mux_combine.sv
// Module: dbg_out_mux_combine
// AND-OR combine of the padded source words under a one-hot select.
// Assumes sel_oh is one-hot or zero; with no select the word is all ones.
module dbg_out_mux_combine #(
    parameter int unsigned N_SRC = 4,
    parameter int unsigned OUT_W = 16
) (
    input  logic [N_SRC-1:0][OUT_W-1:0] words,
    input  logic [N_SRC-1:0]            sel_oh,
    input  logic                        sel_valid,
    output logic [OUT_W-1:0]            word_out
);
    logic [OUT_W-1:0] or_tree;

    // OR together the selected words; unselected ones contribute zero
    always_comb begin
        or_tree = '0;
        for (int i = 0; i < N_SRC; i++) begin
            or_tree = or_tree | (words[i] & {OUT_W{sel_oh[i]}});
        end
    end

    // Idle pattern of all ones when no legal select is present
    always_comb begin
        word_out = sel_valid ? or_tree : '1;
    end
endmodule

// File: rtl/dbg_out_mux.sv
// Module: dbg_out_mux
// Shares one output word among four sources of different widths. The
// source whose reset line alone is low drives the low bits, with ones
// above it. REGISTERED=1 adds one flop stage with a synchronous active-low
// reset; REGISTERED=0 makes the block purely combinational, leaving clk
// and rst_n unused.
module dbg_out_mux
    import dbg_out_mux_pkg::*;
#(
    parameter int unsigned A_W        = 7,
    parameter int unsigned B_W        = 8,
    parameter int unsigned C_W        = 12,
    parameter int unsigned D_W        = 16,
    parameter bit          REGISTERED = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [A_W-1:0]   src_a_data,
    input  logic [B_W-1:0]   src_b_data,
    input  logic [C_W-1:0]   src_c_data,
    input  logic [D_W-1:0]   src_d_data,
    input  logic             src_a_rst_n,
    input  logic             src_b_rst_n,
    input  logic             src_c_rst_n,
    input  logic             src_d_rst_n,
    output logic [OUT_W-1:0] mux_data,
    output logic             mux_valid
);
    logic [N_SRC-1:0][OUT_W-1:0] padded;
    sel_t                        rst_vec_n;
    sel_t                        sel_oh;
    logic                        sel_valid;
    word_t                       next_word;

    // Gather the reset lines in source order
    assign rst_vec_n = {src_d_rst_n, src_c_rst_n, src_b_rst_n, src_a_rst_n};

    dbg_out_mux_pad #(.IN_W(A_W), .OUT_W(OUT_W)) u_pad_a (
        .din (src_a_data),
        .dout(padded[SRC_IDX_A])
    );
    dbg_out_mux_pad #(.IN_W(B_W), .OUT_W(OUT_W)) u_pad_b (
        .din (src_b_data),
        .dout(padded[SRC_IDX_B])
    );
    dbg_out_mux_pad #(.IN_W(C_W), .OUT_W(OUT_W)) u_pad_c (
        .din (src_c_data),
        .dout(padded[SRC_IDX_C])
    );
    dbg_out_mux_pad #(.IN_W(D_W), .OUT_W(OUT_W)) u_pad_d (
        .din (src_d_data),
        .dout(padded[SRC_IDX_D])
    );

    dbg_out_mux_sel #(.N_SRC(N_SRC)) u_sel (
        .rst_lines_n(rst_vec_n),
        .sel_oh     (sel_oh),
        .sel_valid  (sel_valid)
    );

    dbg_out_mux_combine #(.N_SRC(N_SRC), .OUT_W(OUT_W)) u_combine (
        .words    (padded),
        .sel_oh   (sel_oh),
        .sel_valid(sel_valid),
        .word_out (next_word)
    );

    generate
        if (REGISTERED) begin : g_reg
            word_t q_word;
            logic  q_valid;

            // Output flops; the synchronous reset parks the pins at all ones
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q_word  <= '1;
                    q_valid <= 1'b0;
                end else begin
                    q_word  <= next_word;
                    q_valid <= sel_valid;
                end
            end

            assign mux_data  = q_word;
            assign mux_valid = q_valid;

            AST_RESET_IDLE: assert property (@(posedge clk)
                !rst_n |=> (mux_data == '1 && !mux_valid)); // R8
            AST_BAD_PATTERN_ONES: assert property (@(posedge clk) disable iff (!rst_n)
                ($countones(~rst_vec_n) != 1) |=> (mux_data == '1 && !mux_valid)); // R5
            AST_VALID_ON_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
                ($countones(~rst_vec_n) == 1) |=> mux_valid); // R6
            AST_A_PADDED: assert property (@(posedge clk) disable iff (!rst_n)
                (rst_vec_n == 4'b1110) |=> (mux_data[OUT_W-1:A_W] == '1 &&
                                            mux_data[A_W-1:0] == $past(src_a_data))); // R1
            AST_D_PASS: assert property (@(posedge clk) disable iff (!rst_n)
                (rst_vec_n == 4'b0111) |=> (mux_data == OUT_W'($past(src_d_data)))); // R4
        end else begin : g_comb
            // Combinational option: the pins follow the inputs directly
            assign mux_data  = next_word;
            assign mux_valid = sel_valid;
        end
    endgenerate
endmodule

// File: tb/dbg_out_mux_bench.sv
`timescale 1ns/1ps
module dbg_out_mux_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  a_d = '0;
    logic [7:0]  b_d = '0;
    logic [11:0] c_d = '0;
    logic [15:0] d_d = '0;
    logic [3:0]  rl_n = 4'hF;   // {d,c,b,a}
    logic [15:0] mux_data;
    logic        mux_valid;

    int n_checks = 0;
    int n_fail   = 0;
    logic [15:0] exp_data = 16'hFFFF;
    logic        exp_valid = 1'b0;
    logic [16:0] hist[$];

    always #2 clk = ~clk;   // 250 MHz

    dbg_out_mux u_dbg_out_mux (
        .clk(clk), .rst_n(rst_n),
        .src_a_data(a_d), .src_b_data(b_d), .src_c_data(c_d), .src_d_data(d_d),
        .src_a_rst_n(rl_n[0]), .src_b_rst_n(rl_n[1]),
        .src_c_rst_n(rl_n[2]), .src_d_rst_n(rl_n[3]),
        .mux_data(mux_data), .mux_valid(mux_valid)
    );

    // Behavioural reference of the padding rules
    function automatic logic [16:0] model(input logic grst_n, input logic [3:0] lines_n,
                                          input logic [6:0] a, input logic [7:0] b,
                                          input logic [11:0] c, input logic [15:0] d);
        int lows = 0;
        for (int i = 0; i < 4; i++) if (!lines_n[i]) lows++;
        if (!grst_n || lows != 1) return {1'b0, 16'hFFFF};
        case (lines_n)
            4'b1110: return {1'b1, 9'h1FF, a};
            4'b1101: return {1'b1, 8'hFF, b};
            4'b1011: return {1'b1, 4'hF, c};
            default: return {1'b1, d};
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] lines_n);
        case (lines_n)
            4'b1110: return "R1";
            4'b1101: return "R2";
            4'b1011: return "R3";
            4'b0111: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input string req, input logic [15:0] exp_d, input logic exp_v);
        n_checks++;
        if (mux_data !== exp_d || mux_valid !== exp_v) begin
            n_fail++;
            $display("FAIL %s: got data=%h valid=%b, expected data=%h valid=%b",
                     req, mux_data, mux_valid, exp_d, exp_v);
        end
    endtask

    // Drive at negedge, check mid-cycle for hold (R7), check after the edge
    task automatic step(input logic grst_n, input logic [3:0] lines_n, input logic [6:0] a,
                        input logic [7:0] b, input logic [11:0] c, input logic [15:0] d,
                        input string req);
        logic [16:0] m;
        @(negedge clk);
        rst_n = grst_n; rl_n = lines_n; a_d = a; b_d = b; c_d = c; d_d = d;
        m = model(grst_n, lines_n, a, b, c, d);
        hist.push_back(m);
        #1;
        check("R7 hold", exp_data, exp_valid);
        @(negedge clk);
        m = hist.pop_front();
        exp_data = m[15:0]; exp_valid = m[16];
        check(req, exp_data, exp_valid);
        if (lines_n inside {4'b1110, 4'b1101, 4'b1011, 4'b0111} || !grst_n)
            ;
        else check("R6 valid low", exp_data, 1'b0);
    endtask

    initial begin : watchdog
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : stimulus
        logic [3:0] one_low;
        // R8: reset state, with a legal select present
        step(1'b0, 4'b1110, 7'h55, 8'hAA, 12'h123, 16'h4567, "R8");
        step(1'b0, 4'b0111, 7'h01, 8'h02, 12'h003, 16'h0004, "R8");
        // All 16 patterns with random data (R1..R5, R6)
        for (int rep = 0; rep < 8; rep++) begin
            for (int p = 0; p < 16; p++) begin
                step(1'b1, 4'(p), 7'($urandom), 8'($urandom), 12'($urandom), 16'($urandom),
                     req_of(4'(p)));
            end
        end
        // Corner words: all-zero and all-one data on the selected source
        step(1'b1, 4'b1110, 7'h00, 8'hFF, 12'hFFF, 16'hFFFF, "R1");
        step(1'b1, 4'b1101, 7'h7F, 8'h00, 12'hFFF, 16'hFFFF, "R2");
        step(1'b1, 4'b1011, 7'h7F, 8'hFF, 12'h000, 16'hFFFF, "R3");
        step(1'b1, 4'b0111, 7'h7F, 8'hFF, 12'hFFF, 16'h0000, "R4");
        // R9: vary only unselected sources; output must track selected one only
        for (int s = 0; s < 4; s++) begin
            one_low = ~(4'b1 << s);
            for (int k = 0; k < 4; k++) begin
                step(1'b1, one_low,
                     (s == 0) ? 7'h2A  : 7'($urandom),
                     (s == 1) ? 8'h5C  : 8'($urandom),
                     (s == 2) ? 12'hA5 : 12'($urandom),
                     (s == 3) ? 16'hC3C3 : 16'($urandom), "R9");
            end
        end
        // R8 mid-run: global reset overrides a legal select
        step(1'b0, 4'b1011, 7'h11, 8'h22, 12'h333, 16'h4444, "R8");
        step(1'b1, 4'b1011, 7'h11, 8'h22, 12'h333, 16'h4444, "R3");
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule